// File: doc/BRIEF.md
# Programmable Serial Bit-Rate Clock Generator

This block derives a clock at sixteen times a chosen serial bit rate from one master clock, nominally 2.4576 MHz, for use as the sampling clock of a UART. The master clock either comes from the crystal path, which is modelled as the system clock `clk` so that every cycle is a master tick, or comes from an external clock pin `ext_clk`. In the external case each rising edge of `ext_clk`, sampled on `clk`, is one master tick. The level of `xtal_sel` chooses the path. Every rate scales with the master frequency, so no rate is fixed in absolute time.

Master ticks pass first to a three-stage binary prescaler whose stage outputs leave the block on `tap_q`, and then to a rate divider. A four-bit code `rate_sel` picks one of thirteen rates (50 to 9600 baud), or it passes `ext_rate_in` straight to the output so that the user can feed another frequency or a static level for zero baud. The divider loads a new code only when the current half period of the output ends, so the output never shows a runt pulse. The gated master tick leaves the block on `mclk_out` so that further channels can be built from it.

An initialization controller is the source of the divider-chain reset. It has three states. `ST_XTAL` is the crystal mode, and in it a high level on `ext_clk` holds the chain in reset. `ST_ARMED` is the external mode before its first pulse. `ST_RUN` is the external mode after that pulse. The transitions are as follows. Any state goes to `ST_XTAL` while `xtal_sel` is high. `ST_XTAL` goes to `ST_ARMED` when `xtal_sel` is low. `ST_ARMED` goes to `ST_RUN` on the first sampled high level of `ext_clk`, and that level fires one initialization. `ST_RUN` stays until `xtal_sel` rises. The 1800-baud divider runs a three-phase sequence of its own: `PH_FIRST`, then `PH_SECOND`, then `PH_LONG`, then back to `PH_FIRST`. It advances one phase on every terminal count.

Top module: `bitrate_gen`

## Requirements
- R1: `mclk_out` is high in every cycle while `xtal_sel`=1 and `ext_clk`=0. While `xtal_sel`=0, each rising edge of `ext_clk` after the arming pulse advances the chain by exactly one tick, however long `ext_clk` stays high.
- R2: `tap_q` counts master ticks modulo 8 (bit 0 has the lowest weight). An initialization clears it to 0.
- R3: With the time unit U = 8 master ticks, `rate_out` is a square wave whose half period is H units. The codes and half periods are: 0000 9600 H=1; 1100 9600 H=1; 0001 4800 H=2; 1111 2400 H=4; 1110 1200 H=8; 0011 600 H=16; 1101 300 H=32; 0100 200 H=48; 1011 150 H=64; 0101 134.5 H=71; 0111 110 H=87; 0110 75 H=128; 1000 50 H=192. The period is therefore 16·H master ticks.
- R4: Code 0010 (1800 baud) uses half periods of 5, 5, 6, 5, 5, 6 … units, starting from an initialization. The rising-edge intervals are then 88, 80, 88 master ticks, and three consecutive periods sum to 256.
- R5: Codes 1001 and 1010 drive `rate_out` from `ext_rate_in` within the same cycle, including a static level for zero baud.
- R6: A new `rate_sel` takes effect only at the end of the current half period. The half period in progress keeps its old length.
- R7: While `xtal_sel`=1 and `ext_clk`=1, the chain is held in reset: `tap_q` stays 0 and `mclk_out` is 0.
- R8: With `xtal_sel`=0, the first high level sampled on `ext_clk` after `xtal_sel` falls fires one initialization and no tick. Later high levels do not initialize again.
- R9: `rst_n` low clears the chain at once: `tap_q`=0, and `rate_out`=0 for an internal rate.
- R10: After an initialization, the first rising edge of `rate_out` comes 8·H master ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; it is the master clock in crystal mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_sel | input | 1 | 1 = crystal path is the master clock; 0 = `ext_clk` edges |
| ext_clk | input | 1 | External master clock; in crystal mode a high level forces reset |
| rate_sel | input | 4 | Rate code |
| ext_rate_in | input | 1 | External rate or static level for codes 1001/1010 |
| tap_q | output | PRE_W | Prescaler stage outputs |
| mclk_out | output | 1 | Gated master tick strobe |
| rate_out | output | 1 | Clock at 16× the chosen bit rate |

## Verification
The bench builds the block with its default values: a three-stage prescaler (unit of 8 master ticks) and an 8-bit half-period counter. The counter is wide enough for the longest half period of 192 units, so every code, including 50 baud, can be measured edge to edge within a short run. Because the crystal path is one tick per cycle, measured periods map directly to the tick counts in the requirements. The same defaults let the external-clock mode be shown by a handful of pulses through one wrap of the prescaler.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;

    typedef enum logic [1:0] {
        ST_XTAL  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } init_state_e;

    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_LONG   = 2'd2
    } frac_phase_e;

    localparam logic [3:0] SEL_1800  = 4'b0010;
    localparam logic [3:0] SEL_EXT_A = 4'b1001;
    localparam logic [3:0] SEL_EXT_B = 4'b1010;

    function automatic logic sel_is_ext(input logic [3:0] s);
        return (s == SEL_EXT_A) || (s == SEL_EXT_B);
    endfunction

    // Half period in prescaled units; external codes use 1 so the
    // code register is reloaded every unit while passing the input.
    function automatic logic [7:0] half_units(input logic [3:0] s);
        logic [7:0] h;
        unique case (s)
            4'b0000: h = 8'd1;
            4'b0001: h = 8'd2;
            4'b0010: h = 8'd5;
            4'b0011: h = 8'd16;
            4'b0100: h = 8'd48;
            4'b0101: h = 8'd71;
            4'b0110: h = 8'd128;
            4'b0111: h = 8'd87;
            4'b1000: h = 8'd192;
            4'b1001: h = 8'd1;
            4'b1010: h = 8'd1;
            4'b1011: h = 8'd64;
            4'b1100: h = 8'd1;
            4'b1101: h = 8'd32;
            4'b1110: h = 8'd8;
            default: h = 8'd4;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/bitrate_init_ctl.sv
module bitrate_init_ctl
    import bitrate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_sel,
    input  logic ext_clk,
    output logic init,
    output logic mtick
);

    init_state_e state_q, state_d;
    logic        cp_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_XTAL;
            cp_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cp_q    <= ext_clk;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (xtal_sel) begin
            state_d = ST_XTAL;
        end else begin
            unique case (state_q)
                ST_XTAL:  state_d = ST_ARMED;
                ST_ARMED: state_d = ext_clk ? ST_RUN : ST_ARMED;
                ST_RUN:   state_d = ST_RUN;
                default:  state_d = ST_XTAL;
            endcase
        end
    end

    // outputs
    always_comb begin
        init  = 1'b0;
        mtick = 1'b0;
        unique case (state_q)
            ST_XTAL: begin
                init  = xtal_sel & ext_clk;
                mtick = xtal_sel | (ext_clk & ~cp_q);
            end
            ST_ARMED: begin
                init  = ext_clk;
                mtick = xtal_sel | (ext_clk & ~cp_q);
            end
            ST_RUN: begin
                init  = xtal_sel & ext_clk;
                mtick = xtal_sel | (ext_clk & ~cp_q);
            end
            default: begin
                init  = 1'b1;
                mtick = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bitrate_prescale.sv
module bitrate_prescale #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [PRE_W-1:0] q,
    output logic             wrap
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] flip;

    // each stage toggles when all lower stages are high
    for (genvar i = 0; i < PRE_W; i++) begin : g_stage
        if (i == 0) begin : g_lsb
            assign flip[i] = adv;
        end else begin : g_upper
            assign flip[i] = adv & (&cnt_q[i-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q ^ flip;
        end
    end

    assign q    = cnt_q;
    assign wrap = adv & (&cnt_q);

endmodule

// File: rtl/bitrate_rate_div.sv
module bitrate_rate_div
    import bitrate_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       step,
    input  logic [3:0] sel_in,
    input  logic       ext_in,
    output logic       rate_o,
    output logic       ext_act
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       act_q;
    logic             z_q;
    frac_phase_e      ph_q, ph_d;
    logic [CNT_W-1:0] base_lim;
    logic [CNT_W-1:0] lim;
    logic             long_extra;
    logic             term;

    always_comb begin
        base_lim   = CNT_W'(half_units(act_q));
        long_extra = (act_q == SEL_1800) && (ph_q == PH_LONG);
        lim        = base_lim + {{(CNT_W-1){1'b0}}, long_extra};
        term       = (cnt_q == lim - ONE);
    end

    // phase sequence for the fractional rate
    always_comb begin
        unique case (ph_q)
            PH_FIRST:  ph_d = PH_SECOND;
            PH_SECOND: ph_d = PH_LONG;
            PH_LONG:   ph_d = PH_FIRST;
            default:   ph_d = PH_FIRST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            z_q   <= 1'b0;
            act_q <= '0;
            ph_q  <= PH_FIRST;
        end else if (clr) begin
            cnt_q <= '0;
            z_q   <= 1'b0;
            act_q <= sel_in;
            ph_q  <= PH_FIRST;
        end else if (step) begin
            if (term) begin
                cnt_q <= '0;
                z_q   <= ~z_q;
                act_q <= sel_in;
                ph_q  <= ph_d;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    always_comb begin
        ext_act = sel_is_ext(act_q);
        rate_o  = ext_act ? ext_in : z_q;
    end

endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen #(
    parameter int PRE_W = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_sel,
    input  logic             ext_clk,
    input  logic [3:0]       rate_sel,
    input  logic             ext_rate_in,
    output logic [PRE_W-1:0] tap_q,
    output logic             mclk_out,
    output logic             rate_out
);

    logic init_w;
    logic mtick_w;
    logic wrap_w;
    logic ext_act;

    bitrate_init_ctl u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .xtal_sel (xtal_sel),
        .ext_clk  (ext_clk),
        .init     (init_w),
        .mtick    (mtick_w)
    );

    assign mclk_out = mtick_w & ~init_w;

    bitrate_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (init_w),
        .adv   (mclk_out),
        .q     (tap_q),
        .wrap  (wrap_w)
    );

    bitrate_rate_div #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (init_w),
        .step    (wrap_w),
        .sel_in  (rate_sel),
        .ext_in  (ext_rate_in),
        .rate_o  (rate_out),
        .ext_act (ext_act)
    );

endmodule

// File: rtl/bitrate_gen_chk.sv
module bitrate_gen_chk #(
    parameter int PRE_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xtal_sel,
    input logic             ext_clk,
    input logic [PRE_W-1:0] tap_q,
    input logic             mclk_out,
    input logic             rate_out,
    input logic             init_w,
    input logic             ext_act
);

    assert_xtal_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal_sel && !ext_clk) |-> mclk_out);

    assert_tap_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_out |=> (tap_q == $past(tap_q) + PRE_W'(1)));

    assert_tap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_out |=> (tap_q == $past(tap_q) || tap_q == '0));

    assert_hold_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal_sel && ext_clk) |=> (tap_q == '0));

    assert_no_stray_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_act && $past(!ext_act) && !$past(init_w) && rate_out != $past(rate_out))
            |-> $past(mclk_out));

endmodule

bind bitrate_gen bitrate_gen_chk #(.PRE_W(PRE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xtal_sel (xtal_sel),
    .ext_clk  (ext_clk),
    .tap_q    (tap_q),
    .mclk_out (mclk_out),
    .rate_out (rate_out),
    .init_w   (init_w),
    .ext_act  (ext_act)
);

// File: tb/tb_bitrate_gen.sv
module tb_bitrate_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtal = 1'b1;
    logic       cpin = 1'b0;
    logic       im = 1'b0;
    logic [3:0] sel = 4'b0000;
    logic [2:0] q;
    logic       co;
    logic       z;

    bitrate_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .xtal_sel    (xtal),
        .ext_clk     (cpin),
        .rate_sel    (sel),
        .ext_rate_in (im),
        .tap_q       (q),
        .mclk_out    (co),
        .rate_out    (z)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    int m_st, m_cpq, m_pre, m_cnt, m_zd, m_code, m_frac, m_lim;
    bit m_mt, m_ini, m_ptick;
    int e_co, e_z;

    function automatic int half_of(input int c);
        case (c)
            0: return 1;    1: return 2;    2: return 5;    3: return 16;
            4: return 48;   5: return 71;   6: return 128;  7: return 87;
            8: return 192;  9: return 1;    10: return 1;   11: return 64;
            12: return 1;   13: return 32;  14: return 8;   default: return 4;
        endcase
    endfunction

    function automatic bit ext_of(input int c);
        return (c == 9) || (c == 10);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_cpq = 0; m_pre = 0; m_cnt = 0;
            m_zd = 0; m_code = 0; m_frac = 0;
        end else begin
            m_mt  = xtal ? 1'b1 : (cpin && !m_cpq);
            m_ini = xtal ? cpin : (m_st == 1 && cpin);
            if (xtal) m_st = 0;
            else if (m_st == 0) m_st = 1;
            else if (m_st == 1 && cpin) m_st = 2;
            m_cpq = cpin;
            if (m_ini) begin
                m_pre = 0; m_cnt = 0; m_zd = 0; m_code = sel; m_frac = 0;
            end else if (m_mt) begin
                m_ptick = (m_pre == 7);
                m_pre = (m_pre + 1) % 8;
                if (m_ptick) begin
                    m_lim = half_of(m_code) + ((m_code == 2 && m_frac == 2) ? 1 : 0);
                    if (m_cnt == m_lim - 1) begin
                        m_cnt = 0; m_zd = 1 - m_zd; m_code = sel;
                        m_frac = (m_frac + 1) % 3;
                    end else begin
                        m_cnt++;
                    end
                end
            end
        end
        #(CLK_PERIOD/4);
        if (!done) begin
            e_co = ((xtal ? 1 : (cpin && !m_cpq)) && !(xtal ? cpin : (m_st == 1 && cpin))) ? 1 : 0;
            e_z  = ext_of(m_code) ? int'(im) : m_zd;
            chk("R2 tap_q model", int'(q), m_pre);
            chk("R1 mclk_out model", int'(co), e_co);
            chk("R3 rate_out model", int'(z), e_z);
        end
    end

    task automatic wait_edge(input logic lvl, output int at);
        logic prev;
        prev = z;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4 + 1);
            if (z != prev && z == lvl) break;
            prev = z;
        end
        at = cyc;
    endtask

    task automatic xtal_init(input logic [3:0] code, output int t_init);
        @(negedge clk);
        xtal = 1'b1; sel = code; cpin = 1'b1;
        @(negedge clk);
        cpin = 1'b0;
        t_init = cyc;
    endtask

    task automatic pulse_cp();
        @(negedge clk); cpin = 1'b1;
        @(negedge clk); cpin = 1'b0;
    endtask

    task automatic report();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        report();
    end

    initial begin
        int ti, t1, t2, t3, t4, tf;
        int codes[13] = '{0, 1, 15, 14, 3, 13, 4, 11, 5, 7, 6, 8, 12};
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset tap_q", int'(q), 0);
        chk("R9 reset rate_out", int'(z), 0);
        rst_n = 1'b1;

        // R3 / R10: period of every internal code
        foreach (codes[k]) begin
            xtal_init(4'(codes[k]), ti);
            wait_edge(1'b1, t1);
            chk($sformatf("R10 first rise code %0d", codes[k]), t1 - ti, 8 * half_of(codes[k]));
            wait_edge(1'b1, t2);
            wait_edge(1'b1, t3);
            chk($sformatf("R3 period code %0d", codes[k]), t3 - t2, 16 * half_of(codes[k]));
        end

        // R4: fractional 1800 baud
        xtal_init(4'b0010, ti);
        wait_edge(1'b1, t1);
        chk("R10 first rise 1800", t1 - ti, 40);
        wait_edge(1'b1, t2);
        wait_edge(1'b1, t3);
        wait_edge(1'b1, t4);
        chk("R4 interval a", t2 - t1, 88);
        chk("R4 interval b", t3 - t2, 80);
        chk("R4 three periods", t4 - t1, 256);

        // R6: change during a long half period
        xtal_init(4'b1000, ti);
        wait_edge(1'b1, t1);
        repeat (300) @(negedge clk);
        sel = 4'b0000;
        wait_edge(1'b0, tf);
        chk("R6 old half kept", tf - t1, 1536);
        wait_edge(1'b1, t2);
        chk("R6 new half", t2 - tf, 8);

        // R5: external pass-through and zero baud
        xtal_init(4'b1001, ti);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            im = (i % 3 == 1);
            #1;
            chk("R5 pass code 1001", int'(z), int'(im));
        end
        xtal_init(4'b1010, ti);
        @(negedge clk); im = 1'b1;
        repeat (40) @(negedge clk);
        chk("R5 static high code 1010", int'(z), 1);
        @(negedge clk); im = 1'b0;
        #1;
        chk("R5 static low code 1010", int'(z), 0);

        // R7: held reset in crystal mode
        xtal_init(4'b0000, ti);
        repeat (5) @(negedge clk);
        cpin = 1'b1;
        repeat (20) begin
            @(negedge clk);
            chk("R7 tap_q held", int'(q), 0);
            chk("R7 mclk_out off", int'(co), 0);
        end
        cpin = 1'b0;

        // R8 / R1: external clock mode
        @(negedge clk); xtal = 1'b0;
        repeat (3) @(negedge clk);
        pulse_cp();
        chk("R8 first pulse initializes", int'(q), 0);
        repeat (5) pulse_cp();
        chk("R1 ext ticks", int'(q), 5);
        repeat (6) pulse_cp();
        chk("R8 no second init", int'(q), 3);
        @(negedge clk); cpin = 1'b1;
        repeat (5) @(negedge clk);
        cpin = 1'b0;
        @(negedge clk);
        chk("R1 long high one tick", int'(q), 4);
        @(negedge clk); xtal = 1'b1;
        repeat (20) @(negedge clk);

        // R9: asynchronous reset mid-run
        xtal_init(4'b0000, ti);
        repeat (13) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R9 async tap_q", int'(q), 0);
        chk("R9 async rate_out", int'(z), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);

        report();
    end

endmodule